// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block is the sequencing half of a microprogrammed control unit. It keeps a writable control store of microinstructions and a control address register that points at the word being fetched. A control data register captures that word. A one-deep return register saves the place a micro-subroutine was called from. Every microinstruction is fetched in one cycle and executed in the next. During the execute cycle the block presents the control word to the datapath. It also picks the next control address from four sources: the incremented address, the branch target, the saved return address, or the start of the routine that serves the current machine opcode.

A microinstruction word, most significant field first, is: control word (`CWW` bits), condition select (2 bits), branch type (2 bits), target address (`AW` bits, the lowest bits). Condition select codes are 0 = always, 1 = flag bit 0, 2 = flag bit 1, 3 = flag bit 2. Branch type codes are 0 = jump, 1 = call, 2 = return, 3 = opcode map. The parameter `MAP_MODE` picks how an opcode becomes a routine start. Value 0 uses shift mapping: the opcode times 2^`SHIFT_K`, cut to `AW` bits, so every routine gets an equal power-of-two slot. Value 1 uses a writable table of 2^`OPW` start addresses, so routines may differ in length.

The controller has three states, named in the RTL `ST_HALT`, `ST_FETCH` and `ST_EXEC`. It has four transitions:
- Start: `ST_HALT` to `ST_FETCH` when `run` is high.
- Load: `ST_FETCH` to `ST_EXEC`, unconditional.
- Continue: `ST_EXEC` to `ST_FETCH` when `run` is high.
- Stop: `ST_EXEC` to `ST_HALT` when `run` is low.

Reset enters `ST_HALT`.

Top module: `useq_top`

## Requirements
- R1: While `rst_n` is low and afterwards until `run` goes high, `car` equals 0 (the reset address) and `ctl_valid` is 0.
- R2: Each microinstruction takes a fetch cycle then an execute cycle. `ctl_valid` is high only in the execute cycle, never two cycles in a row, and `car` changes only at the clock edge that ends an execute cycle.
- R3: When the selected condition is false (code 0 = always, 1/2/3 = flags bit 0/1/2), the next `car` is the current `car` plus 1, wrapping modulo 2^`AW`, whatever the branch type.
- R4: A jump (type 0) with a true condition loads `car` from the target address field.
- R5: A call (type 1) with a true condition loads `car` from the target field and writes `car`+1 (modulo 2^`AW`) into the return register. A second call replaces the saved value. The return register changes at no other time.
- R6: A return (type 2) with a true condition loads `car` from the return register.
- R7: With `MAP_MODE`=0, a map (type 3) with a true condition loads `car` with `opcode` shifted left by `SHIFT_K`, truncated to `AW` bits.
- R8: With `MAP_MODE`=1, a map with a true condition loads `car` with table entry `opcode`. Entry `map_idx` is written with `map_wdata` at a clock edge where `map_we` is high.
- R9: At a clock edge where `cfg_we` is high, control store word `cfg_addr` is written with `cfg_wdata`. In the execute cycle of that word, `ctl_word` shows its control word field (bits `WW-1` down to `AW+4`).
- R10: If `run` is low during an execute cycle, `car` still advances once, then the block halts. `car` then holds and `ctl_valid` stays 0 until `run` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Allows sequencing; low halts after the current microinstruction |
| cfg_we | input | 1 | Control store write enable |
| cfg_addr | input | AW | Control store write address |
| cfg_wdata | input | CWW+AW+4 | Microinstruction word to store |
| map_we | input | 1 | Mapping table write enable (table mode) |
| map_idx | input | OPW | Mapping table entry to write |
| map_wdata | input | AW | Routine start address to store |
| opcode | input | OPW | Machine opcode used by map branches |
| flags | input | 3 | Status conditions selectable by microinstructions |
| ctl_word | output | CWW | Control word of the executing microinstruction, 0 otherwise |
| ctl_valid | output | 1 | High in the execute cycle |
| car | output | AW | Control address register |

## Verification
Some pairs of effects fall in the same execute cycle, and each is provoked by placing a microinstruction on purpose:
- A call placed at the top address of the store jumps and, in the same cycle, saves a return address that has wrapped to 0. A later return shows whether the saved value wrapped correctly.
- A map or return whose condition is false tests that the increment wins over the mapping or return source in that same cycle.
- Dropping `run` in an execute cycle tests that the address still advances on the stop transition.

A bench reference model follows every step of both a shift-mapped and a table-mapped instance. It judges each outcome by comparing `car` and `ctl_word` on every execute cycle.

// File: rtl/useq_pkg.sv
package useq_pkg;

    typedef enum logic [1:0] {
        BR_JUMP = 2'd0,
        BR_CALL = 2'd1,
        BR_RET  = 2'd2,
        BR_MAP  = 2'd3
    } br_e;

    typedef enum logic [1:0] {
        CS_ALWAYS = 2'd0,
        CS_FLAG0  = 2'd1,
        CS_FLAG1  = 2'd2,
        CS_FLAG2  = 2'd3
    } csel_e;

    typedef enum logic [1:0] {
        NX_INC  = 2'd0,
        NX_TGT  = 2'd1,
        NX_RET  = 2'd2,
        NX_MAP  = 2'd3
    } nsel_e;

    typedef enum logic [1:0] {
        ST_HALT  = 2'd0,
        ST_FETCH = 2'd1,
        ST_EXEC  = 2'd2
    } st_e;

endpackage

// File: rtl/useq_cmem.sv
module useq_cmem #(
    parameter int AW = 7,
    parameter int WW = 27,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [WW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [WW-1:0] rdata
);

    logic [WW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    assign rdata = store[raddr];

endmodule

// File: rtl/useq_map.sv
module useq_map #(
    parameter int OPW      = 4,
    parameter int AW       = 7,
    parameter int MAP_MODE = 0,
    parameter int SHIFT_K  = 3,
    localparam int ENTRIES = 1 << OPW
) (
    input  logic           clk,
    input  logic           we,
    input  logic [OPW-1:0] widx,
    input  logic [AW-1:0]  wdata,
    input  logic [OPW-1:0] opcode,
    output logic [AW-1:0]  start
);

    generate
        if (MAP_MODE == 0) begin : g_shift
            // Equal power-of-two slots: start = opcode * 2^SHIFT_K mod 2^AW
            logic map_unused;
            assign map_unused = ^{clk, we, widx, wdata};
            assign start = AW'(opcode) << SHIFT_K;
        end else begin : g_table
            logic [AW-1:0] tbl [ENTRIES];
            always_ff @(posedge clk) begin
                if (we) begin
                    tbl[widx] <= wdata;
                end
            end
            assign start = tbl[opcode];
        end
    endgenerate

endmodule

// File: rtl/useq_next.sv
module useq_next
    import useq_pkg::*;
#(
    parameter int AW = 7
) (
    input  logic [AW-1:0] car,
    input  logic [AW-1:0] sbr,
    input  logic [AW-1:0] tgt,
    input  logic [AW-1:0] map_start,
    input  csel_e         csel,
    input  br_e           br,
    input  logic [2:0]    flags,
    output logic          cond_ok,
    output logic          sbr_load,
    output logic [AW-1:0] car_inc,
    output logic [AW-1:0] next_car
);

    nsel_e sel;

    assign car_inc = car + AW'(1);

    // Condition multiplexer
    always_comb begin
        unique case (csel)
            CS_ALWAYS: cond_ok = 1'b1;
            CS_FLAG0:  cond_ok = flags[0];
            CS_FLAG1:  cond_ok = flags[1];
            CS_FLAG2:  cond_ok = flags[2];
            default:   cond_ok = 1'b0;
        endcase
    end

    // Branch logic drives the next-address select lines
    always_comb begin
        sel = NX_INC;
        if (cond_ok) begin
            unique case (br)
                BR_JUMP: sel = NX_TGT;
                BR_CALL: sel = NX_TGT;
                BR_RET:  sel = NX_RET;
                BR_MAP:  sel = NX_MAP;
                default: sel = NX_INC;
            endcase
        end
    end

    assign sbr_load = cond_ok && (br == BR_CALL);

    // Next-address multiplexer
    always_comb begin
        unique case (sel)
            NX_INC:  next_car = car_inc;
            NX_TGT:  next_car = tgt;
            NX_RET:  next_car = sbr;
            NX_MAP:  next_car = map_start;
            default: next_car = car_inc;
        endcase
    end

endmodule

// File: rtl/useq_top.sv
module useq_top
    import useq_pkg::*;
#(
    parameter int AW         = 7,
    parameter int OPW        = 4,
    parameter int CWW        = 16,
    parameter int MAP_MODE   = 0,
    parameter int SHIFT_K    = 3,
    parameter int RESET_ADDR = 0,
    localparam int WW        = CWW + AW + 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic           cfg_we,
    input  logic [AW-1:0]  cfg_addr,
    input  logic [WW-1:0]  cfg_wdata,
    input  logic           map_we,
    input  logic [OPW-1:0] map_idx,
    input  logic [AW-1:0]  map_wdata,
    input  logic [OPW-1:0] opcode,
    input  logic [2:0]     flags,
    output logic [CWW-1:0] ctl_word,
    output logic           ctl_valid,
    output logic [AW-1:0]  car
);

    localparam int TGT_LO = 0;
    localparam int BR_LO  = AW;
    localparam int CS_LO  = AW + 2;
    localparam int CW_LO  = AW + 4;

    st_e           state, state_nx;
    logic [AW-1:0] car_q, sbr_q;
    logic [WW-1:0] cdr_q;
    logic [WW-1:0] cm_rdata;
    logic [AW-1:0] map_start, next_car, car_inc, tgt_addr;
    logic [1:0]    br_bits, cs_bits;
    logic          cond_ok, sbr_load, halted;

    assign tgt_addr = cdr_q[TGT_LO +: AW];
    assign br_bits  = cdr_q[BR_LO +: 2];
    assign cs_bits  = cdr_q[CS_LO +: 2];

    useq_cmem #(.AW(AW), .WW(WW)) u_cmem (
        .clk   (clk),
        .we    (cfg_we),
        .waddr (cfg_addr),
        .wdata (cfg_wdata),
        .raddr (car_q),
        .rdata (cm_rdata)
    );

    useq_map #(.OPW(OPW), .AW(AW), .MAP_MODE(MAP_MODE), .SHIFT_K(SHIFT_K)) u_map (
        .clk    (clk),
        .we     (map_we),
        .widx   (map_idx),
        .wdata  (map_wdata),
        .opcode (opcode),
        .start  (map_start)
    );

    useq_next #(.AW(AW)) u_next (
        .car       (car_q),
        .sbr       (sbr_q),
        .tgt       (tgt_addr),
        .map_start (map_start),
        .csel      (csel_e'(cs_bits)),
        .br        (br_e'(br_bits)),
        .flags     (flags),
        .cond_ok   (cond_ok),
        .sbr_load  (sbr_load),
        .car_inc   (car_inc),
        .next_car  (next_car)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_HALT;
        end else begin
            state <= state_nx;
        end
    end

    // Transitions: start, load, continue, stop
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_HALT:  state_nx = run ? ST_FETCH : ST_HALT;
            ST_FETCH: state_nx = ST_EXEC;
            ST_EXEC:  state_nx = run ? ST_FETCH : ST_HALT;
            default:  state_nx = ST_HALT;
        endcase
    end

    // Address, return and data registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            car_q <= AW'(RESET_ADDR);
            sbr_q <= '0;
            cdr_q <= '0;
        end else begin
            if (state == ST_FETCH) begin
                cdr_q <= cm_rdata;
            end
            if (state == ST_EXEC) begin
                car_q <= next_car;
                if (sbr_load) begin
                    sbr_q <= car_inc;
                end
            end
        end
    end

    // Outputs
    always_comb begin
        ctl_valid = (state == ST_EXEC);
        halted    = (state == ST_HALT);
        ctl_word  = ctl_valid ? cdr_q[CW_LO +: CWW] : '0;
        car       = car_q;
    end

endmodule

// File: rtl/useq_checker.sv
module useq_checker #(
    parameter int AW = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          valid,
    input logic          halted,
    input logic          run,
    input logic          cond_ok,
    input logic [1:0]    br,
    input logic [AW-1:0] car,
    input logic [AW-1:0] sbr,
    input logic [AW-1:0] tgt
);

    assert_exec_once_R2: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    assert_car_only_after_exec_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> $stable(car));

    assert_false_cond_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !cond_ok) |=> (car == $past(car) + AW'(1)));

    assert_jump_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && cond_ok && br == 2'd0) |=> (car == $past(tgt)));

    assert_call_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && cond_ok && br == 2'd1) |=> ((car == $past(tgt)) && (sbr == $past(car) + AW'(1))));

    assert_sbr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid && cond_ok && br == 2'd1) |=> $stable(sbr));

    assert_return_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && cond_ok && br == 2'd2) |=> (car == $past(sbr)));

    assert_halt_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !run) |=> (halted && $stable(car)));

endmodule

bind useq_top useq_checker #(.AW(AW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid   (ctl_valid),
    .halted  (halted),
    .run     (run),
    .cond_ok (cond_ok),
    .br      (br_bits),
    .car     (car),
    .sbr     (sbr_q),
    .tgt     (tgt_addr)
);

// File: tb/useq_top_tb.sv
module useq_top_tb;

    localparam int AW  = 7;
    localparam int OPW = 4;
    localparam int CWW = 16;
    localparam int WW  = CWW + AW + 4;
    localparam int K   = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           run = 1'b0;
    logic           cfg_we = 1'b0;
    logic [AW-1:0]  cfg_addr = '0;
    logic [WW-1:0]  cfg_wdata = '0;
    logic           map_we = 1'b0;
    logic [OPW-1:0] map_idx = '0;
    logic [AW-1:0]  map_wdata = '0;
    logic [OPW-1:0] opcode = '0;
    logic [2:0]     flags = '0;

    logic [CWW-1:0] cw_t, cw_s;
    logic           v_t, v_s;
    logic [AW-1:0]  car_t, car_s;

    int total = 0;
    int bad = 0;
    bit timed_out = 0;

    // Reference model state
    logic [WW-1:0] cm_m [1 << AW];
    logic [AW-1:0] map_m [1 << OPW];
    logic [AW-1:0] mcar_t, msbr_t, mcar_s, msbr_s;

    always #2 clk = ~clk;

    useq_top #(.AW(AW), .OPW(OPW), .CWW(CWW), .MAP_MODE(1), .SHIFT_K(K)) u_dut (
        .clk(clk), .rst_n(rst_n), .run(run), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .map_we(map_we), .map_idx(map_idx), .map_wdata(map_wdata),
        .opcode(opcode), .flags(flags), .ctl_word(cw_t), .ctl_valid(v_t), .car(car_t)
    );

    useq_top #(.AW(AW), .OPW(OPW), .CWW(CWW), .MAP_MODE(0), .SHIFT_K(K)) u_dut_sh (
        .clk(clk), .rst_n(rst_n), .run(run), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .map_we(map_we), .map_idx(map_idx), .map_wdata(map_wdata),
        .opcode(opcode), .flags(flags), .ctl_word(cw_s), .ctl_valid(v_s), .car(car_s)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put_cm(input int a, input logic [15:0] cw, input int cs, input int br, input int tgt);
        logic [WW-1:0] w;
        w = {cw, 2'(cs), 2'(br), 7'(tgt)};
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 7'(a); cfg_wdata = w;
        @(negedge clk);
        cfg_we = 1'b0;
        cm_m[a] = w;
    endtask

    task automatic put_map(input int i, input int v);
        @(negedge clk);
        map_we = 1'b1; map_idx = 4'(i); map_wdata = 7'(v);
        @(negedge clk);
        map_we = 1'b0;
        map_m[i] = 7'(v);
    endtask

    task automatic do_reset();
        @(negedge clk);
        run = 1'b0; rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        mcar_t = '0; msbr_t = '0; mcar_s = '0; msbr_s = '0;
    endtask

    task automatic model_next(input logic [AW-1:0] c, input logic [AW-1:0] s, input bit table_mode,
                              output logic [AW-1:0] nc, output logic [AW-1:0] ns, output string tag);
        logic [WW-1:0] w;
        logic ok;
        int cs, br;
        w  = cm_m[c];
        cs = int'(w[AW+3:AW+2]);
        br = int'(w[AW+1:AW]);
        ok = (cs == 0) ? 1'b1 : flags[cs-1];
        ns = s;
        if (!ok) begin
            nc = c + 7'd1; tag = "R3";
        end else begin
            case (br)
                0: begin nc = w[AW-1:0]; tag = "R4"; end
                1: begin nc = w[AW-1:0]; ns = c + 7'd1; tag = "R5"; end
                2: begin nc = s; tag = "R6"; end
                default: begin
                    if (table_mode) begin nc = map_m[opcode]; tag = "R8"; end
                    else begin nc = 7'((int'(opcode) << K) % (1 << AW)); tag = "R7"; end
                end
            endcase
        end
    endtask

    // One microinstruction: wait for execute, check, advance model
    task automatic step();
        int n = 0;
        string tg_t, tg_s;
        logic [AW-1:0] nc, ns;
        @(negedge clk);
        while (!v_t && n < 20) begin
            @(negedge clk);
            n++;
        end
        chk("R2 exec cycle reached", {31'd0, v_t && v_s}, 32'd1);
        chk("R9 R2 control word (table)", 32'(cw_t), 32'(cm_m[mcar_t][WW-1:AW+4]));
        chk("R9 R2 control word (shift)", 32'(cw_s), 32'(cm_m[mcar_s][WW-1:AW+4]));
        chk("R2 car during exec (table)", 32'(car_t), 32'(mcar_t));
        chk("R2 car during exec (shift)", 32'(car_s), 32'(mcar_s));
        model_next(mcar_t, msbr_t, 1'b1, nc, ns, tg_t);
        mcar_t = nc; msbr_t = ns;
        model_next(mcar_s, msbr_s, 1'b0, nc, ns, tg_s);
        mcar_s = nc; msbr_s = ns;
        @(negedge clk);
        chk({tg_t, " next address (table)"}, 32'(car_t), 32'(mcar_t));
        chk({tg_s, " next address (shift)"}, 32'(car_s), 32'(mcar_s));
        chk("R2 no valid in fetch", {31'd0, v_t}, 32'd0);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 car at reset", 32'(car_t), 32'd0);
        chk("R1 valid at reset", {31'd0, v_t}, 32'd0);
        repeat (4) @(negedge clk);
        chk("R1 car held while run low", 32'(car_s), 32'd0);
        chk("R1 valid low while run low", {31'd0, v_s}, 32'd0);
    endtask

    task automatic t_branches();
        put_cm(0,  16'h1111, 0, 0, 4);
        put_cm(4,  16'h2222, 1, 0, 10);
        put_cm(5,  16'h3333, 2, 0, 10);
        put_cm(10, 16'h4444, 0, 1, 20);
        put_cm(20, 16'h5555, 3, 1, 30);
        put_cm(30, 16'h6666, 0, 2, 0);
        put_cm(21, 16'h7777, 1, 2, 0);
        put_cm(22, 16'h8888, 0, 2, 0);
        do_reset();
        flags = 3'b110;
        run = 1'b1;
        // 0 jmp->4, 4 F0 false->5, 5 F1 ->10, 10 call->20 (R5),
        // 20 call again ->30 overwrites (R5), 30 ret->21 (R6), 21 F0 false ->22
        for (int i = 0; i < 8; i++) step();
        chk("R6 return after second call lands at 21", 32'(car_t), 32'd21);
    endtask

    task automatic t_mapping();
        put_map(5, 50);
        put_map(15, 127);
        put_cm(0,   16'hA0A0, 0, 3, 0);
        put_cm(40,  16'hB0B0, 0, 0, 0);
        put_cm(50,  16'hC0C0, 2, 3, 0);
        put_cm(51,  16'hD0D0, 0, 0, 0);
        put_cm(120, 16'hE0E0, 0, 0, 0);
        put_cm(127, 16'hF0F0, 0, 1, 60);
        put_cm(60,  16'h0F0F, 0, 2, 0);
        do_reset();
        flags = 3'b000;
        opcode = 4'd5;
        run = 1'b1;
        step();
        chk("R8 table map opcode 5", 32'(car_t), 32'd50);
        chk("R7 shift map opcode 5", 32'(car_s), 32'd40);
        for (int i = 0; i < 3; i++) step();
        opcode = 4'd15;
        // reach map at 0 again, then 127 call wraps saved address to 0
        for (int i = 0; i < 6; i++) step();
    endtask

    task automatic t_halt();
        do_reset();
        flags = 3'b000;
        opcode = 4'd5;
        run = 1'b1;
        @(negedge clk);
        while (!v_t) @(negedge clk);
        run = 1'b0;
        model_step_silent();
        repeat (5) @(negedge clk);
        chk("R10 car advanced once then holds", 32'(car_t), 32'(mcar_t));
        chk("R10 no exec while halted", {31'd0, v_t}, 32'd0);
        run = 1'b1;
        step();
    endtask

    task automatic model_step_silent();
        string tg;
        logic [AW-1:0] nc, ns;
        model_next(mcar_t, msbr_t, 1'b1, nc, ns, tg);
        mcar_t = nc; msbr_t = ns;
        model_next(mcar_s, msbr_s, 1'b0, nc, ns, tg);
        mcar_s = nc; msbr_s = ns;
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_branches();
                t_mapping();
                t_halt();
            end
            begin
                repeat (100000) @(posedge clk);
                timed_out = 1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=expired expected=finished");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule